// File: doc/BRIEF.md
# Sine-Weighted PWM Tone Generator

This block drives a single output bit whose pulse width changes period by period so that its filtered average traces a sine wave. A carrier counter divides the clock into fixed-length periods. At the start of each period a duty value is loaded from a sine table. That table is computed when the design is built and read like a ROM. A separate step divider moves the table pointer at its own programmable rate, and that rate sets the pitch of the tone. The divider is never allowed to run faster than the carrier.

The carrier length in clocks is set at runtime. Each stored table code is a fraction of full scale in offset binary. It is scaled by the current carrier length, so the duty stays centred on half the period whatever length is chosen. A one-cycle strobe marks the first cycle of every carrier period, which lets a monitor line up its measurement windows with the applied duty values.

Top module: `sine_pwm_gen`

## Requirements
- R1: While `rst` is high and on the cycle after, `pwm_o` and `period_start_o` are 0. The first carrier period after reset has a duty of zero, so `pwm_o` stays 0 until the first start strobe.
- R2: `period_start_o` is high for exactly one cycle. It first rises after the P-th enabled clock edge following reset and then after every further P enabled edges. Here P is `period_i`, and settings below 2 act as 2.
- R3: In each carrier period, `pwm_o` is high for exactly floor(P * C / 2^CODE_W) cycles, where C is the table code applied in that period. A code that scales to 0 keeps the output low for the whole period.
- R4: Table entry k of TBL_N holds C(k) = 2^(CODE_W-1) + floor(A*sin(2*pi*k/TBL_N) + 0.5), with A = 2^(CODE_W-1) - 1. This is offset binary about mid-scale, so the mean duty is half the period.
- R5: Period j (counted from 1 at the first start strobe) applies entry floor((j*P - 1) / Seff) mod TBL_N. Here Seff is the effective step divisor, in enabled clocks.
- R6: The effective step divisor Seff is the larger of `step_i` and P, so the table pointer never advances more than once per carrier period.
- R7: After entry TBL_N-1, the pointer goes to entry 0, with no entry skipped or repeated.
- R8: A new duty value takes effect only at a period start. Within a period, `pwm_o` is high on the leading cycles and then low, and it never rises again before the next start.
- R9: While `en` is low, both counters and the table pointer hold their values, and `pwm_o` and `period_start_o` are 0 from the next cycle on. When `en` returns, counting resumes where it stopped, so the interrupted period still totals its full high count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low freezes all counting |
| period_i | input | PER_W | Carrier period length in clocks (P) |
| step_i | input | DIV_W | Table step divisor in clocks |
| pwm_o | output | 1 | Pulse-width-modulated output bit |
| period_start_o | output | 1 | One-cycle strobe on the first cycle of each carrier period |

## Verification
Both outputs are registered. The start strobe and the first cycle of a new duty show up at the sample that follows the enabled edge on which the carrier counter wrapped. The first strobe therefore appears at the P-th sample after reset is released. The bench samples on the falling edge. It starts a window at each strobe and counts the high samples until the next strobe, so every period's high count and length are measured over exactly the cycles that period occupies. Expected duties come from the period count and the closed-form table-pointer schedule, both indexed by enabled edges. Cycles spent with `en` low are checked separately and are left out of that count.

// File: rtl/sine_pwm_pkg.sv
package sine_pwm_pkg;

    localparam real TWO_PI = 6.283185307179586;

    // Offset-binary sine code for entry k of an n-entry table, w bits wide.
    function automatic int sine_code(input int k, input int n, input int w);
        real amp;
        real ang;
        real val;
        amp = real'((1 << (w - 1)) - 1);
        ang = TWO_PI * real'(k) / real'(n);
        val = $floor(amp * $sin(ang) + 0.5);
        return (1 << (w - 1)) + int'(val);
    endfunction

    typedef enum logic {
        MODE_HOLD = 1'b0,
        MODE_RUN  = 1'b1
    } run_mode_e;

endpackage

// File: rtl/sine_pwm_rom.sv
module sine_pwm_rom #(
    parameter int TBL_N  = 64,
    parameter int CODE_W = 8,
    localparam int IW    = $clog2(TBL_N)
) (
    input  logic [IW-1:0]     idx_i,
    output logic [CODE_W-1:0] code_o
);

    logic [CODE_W-1:0] rom [TBL_N];

    for (genvar k = 0; k < TBL_N; k++) begin : g_ent
        localparam int CODE = sine_pwm_pkg::sine_code(k, TBL_N, CODE_W);
        assign rom[k] = CODE[CODE_W-1:0];
    end

    assign code_o = rom[idx_i];

endmodule

// File: rtl/sine_pwm_carrier.sv
module sine_pwm_carrier #(
    parameter int PER_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic [PER_W-1:0] period_i,
    output logic [PER_W-1:0] cnt_o,
    output logic [PER_W-1:0] cnt_next_o,
    output logic             wrap_o
);

    logic [PER_W-1:0] cnt_q;
    logic [PER_W-1:0] last_w;

    // Periods shorter than two clocks are treated as two.
    assign last_w = (period_i > PER_W'(1)) ? period_i - PER_W'(1) : PER_W'(1);
    assign wrap_o = en_i && (cnt_q >= last_w);

    always_comb begin
        if (!en_i) begin
            cnt_next_o = cnt_q;
        end else if (wrap_o) begin
            cnt_next_o = '0;
        end else begin
            cnt_next_o = cnt_q + PER_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_next_o;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/sine_pwm_stepper.sv
module sine_pwm_stepper #(
    parameter int TBL_N = 64,
    parameter int PER_W = 10,
    parameter int DIV_W = 12,
    localparam int IW   = $clog2(TBL_N),
    localparam int EW   = (DIV_W > PER_W) ? DIV_W : PER_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic [PER_W-1:0] period_i,
    input  logic [DIV_W-1:0] step_i,
    output logic [IW-1:0]    idx_o
);

    logic [EW-1:0] step_ext;
    logic [EW-1:0] per_ext;
    logic [EW-1:0] eff_w;
    logic [EW-1:0] div_q;
    logic [IW-1:0] idx_q;
    logic          tick_w;

    assign step_ext = EW'(step_i);
    assign per_ext  = (period_i > PER_W'(1)) ? EW'(period_i) : EW'(2);
    // The step divisor never drops below the carrier length.
    assign eff_w    = (step_ext > per_ext) ? step_ext : per_ext;
    assign tick_w   = en_i && (div_q >= eff_w - EW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            idx_q <= '0;
        end else if (en_i) begin
            if (tick_w) begin
                div_q <= '0;
                if (idx_q == IW'(TBL_N - 1)) begin
                    idx_q <= '0;
                end else begin
                    idx_q <= idx_q + IW'(1);
                end
            end else begin
                div_q <= div_q + EW'(1);
            end
        end
    end

    assign idx_o = idx_q;

endmodule

// File: rtl/sine_pwm_scale.sv
module sine_pwm_scale #(
    parameter int PER_W  = 10,
    parameter int CODE_W = 8,
    localparam int PW    = PER_W + CODE_W
) (
    input  logic [PER_W-1:0]  period_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [PER_W-1:0]  duty_o
);

    logic [PW-1:0] prod_w;

    assign prod_w = {{CODE_W{1'b0}}, period_i} * {{PER_W{1'b0}}, code_i};
    assign duty_o = prod_w[PW-1 -: PER_W];

endmodule

// File: rtl/sine_pwm_gen.sv
module sine_pwm_gen #(
    parameter int TBL_N  = 64,
    parameter int CODE_W = 8,
    parameter int PER_W  = 10,
    parameter int DIV_W  = 12,
    localparam int IW    = $clog2(TBL_N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [PER_W-1:0] period_i,
    input  logic [DIV_W-1:0] step_i,
    output logic             pwm_o,
    output logic             period_start_o
);
    import sine_pwm_pkg::*;

    logic [PER_W-1:0]  cnt_w;
    logic [PER_W-1:0]  cnt_next_w;
    logic              wrap_w;
    logic [IW-1:0]     idx_w;
    logic [CODE_W-1:0] code_w;
    logic [PER_W-1:0]  duty_new_w;
    logic [PER_W-1:0]  duty_next_w;
    logic [PER_W-1:0]  duty_q;
    logic              pwm_q;
    logic              start_q;
    run_mode_e         mode_w;

    sine_pwm_carrier #(.PER_W(PER_W)) u_carrier (
        .clk        (clk),
        .rst        (rst),
        .en_i       (en),
        .period_i   (period_i),
        .cnt_o      (cnt_w),
        .cnt_next_o (cnt_next_w),
        .wrap_o     (wrap_w)
    );

    sine_pwm_stepper #(
        .TBL_N (TBL_N),
        .PER_W (PER_W),
        .DIV_W (DIV_W)
    ) u_stepper (
        .clk      (clk),
        .rst      (rst),
        .en_i     (en),
        .period_i (period_i),
        .step_i   (step_i),
        .idx_o    (idx_w)
    );

    sine_pwm_rom #(.TBL_N(TBL_N), .CODE_W(CODE_W)) u_rom (
        .idx_i  (idx_w),
        .code_o (code_w)
    );

    sine_pwm_scale #(.PER_W(PER_W), .CODE_W(CODE_W)) u_scale (
        .period_i (period_i),
        .code_i   (code_w),
        .duty_o   (duty_new_w)
    );

    assign mode_w      = en ? MODE_RUN : MODE_HOLD;
    assign duty_next_w = wrap_w ? duty_new_w : duty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            duty_q  <= '0;
            pwm_q   <= 1'b0;
            start_q <= 1'b0;
        end else begin
            case (mode_w)
                MODE_RUN: begin
                    duty_q  <= duty_next_w;
                    pwm_q   <= (cnt_next_w < duty_next_w);
                    start_q <= wrap_w;
                end
                default: begin
                    pwm_q   <= 1'b0;
                    start_q <= 1'b0;
                end
            endcase
        end
    end

    assign pwm_o          = pwm_q;
    assign period_start_o = start_q;

endmodule

// File: rtl/sine_pwm_checks.sv
module sine_pwm_checks #(
    parameter int TBL_N = 64,
    parameter int PER_W = 10,
    localparam int IW   = $clog2(TBL_N)
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic [PER_W-1:0] period_i,
    input logic             pwm_o,
    input logic             start_o,
    input logic [PER_W-1:0] cnt_q,
    input logic [PER_W-1:0] duty_q,
    input logic             wrap,
    input logic [IW-1:0]    idx_q
);

    logic [IW-1:0] prev_idx_q;
    logic [31:0]   gap_q;
    logic          chg_w;

    assign chg_w = (idx_q != prev_idx_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_idx_q <= '0;
            gap_q      <= '0;
        end else begin
            prev_idx_q <= idx_q;
            if (chg_w) begin
                gap_q <= '0;
            end else if (en && gap_q != 32'hFFFF_FFFF) begin
                gap_q <= gap_q + 32'd1;
            end
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!pwm_o && !start_o));

    assert_start_single_R2: assert property (@(posedge clk) disable iff (rst)
        start_o |=> !start_o);

    assert_pwm_below_duty_R3: assert property (@(posedge clk) disable iff (rst)
        pwm_o |-> (cnt_q < duty_q));

    assert_step_spacing_R6: assert property (@(posedge clk) disable iff (rst)
        chg_w |-> (gap_q >= 32'(period_i) - 32'd1));

    assert_index_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (idx_q == IW'(TBL_N - 1)) |=> (idx_q == '0 || idx_q == IW'(TBL_N - 1)));

    assert_duty_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(duty_q));

    assert_hold_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!pwm_o && !start_o));

endmodule

bind sine_pwm_gen sine_pwm_checks #(
    .TBL_N (TBL_N),
    .PER_W (PER_W)
) u_checks (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .period_i (period_i),
    .pwm_o    (pwm_o),
    .start_o  (period_start_o),
    .cnt_q    (cnt_w),
    .duty_q   (duty_q),
    .wrap     (wrap_w),
    .idx_q    (idx_w)
);

// File: tb/sine_pwm_gen_bench.sv
module sine_pwm_gen_bench;

    localparam int N  = 16;
    localparam int CW = 8;
    localparam int PW = 8;
    localparam int DW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en  = 1'b0;
    logic [PW-1:0] per = '0;
    logic [DW-1:0] stp = '0;
    logic          pwm;
    logic          st;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    sine_pwm_gen #(
        .TBL_N  (N),
        .CODE_W (CW),
        .PER_W  (PW),
        .DIV_W  (DW)
    ) u_sine_pwm_gen (
        .clk            (clk),
        .rst            (rst),
        .en             (en),
        .period_i       (per),
        .step_i         (stp),
        .pwm_o          (pwm),
        .period_start_o (st)
    );

    // R4: offset-binary sine code from the requirement formula
    function automatic int code_of(input int k);
        real v;
        v = $sin(2.0 * 3.141592653589793 * real'(k) / real'(N)) * 127.0;
        return 128 + int'($floor(v + 0.5));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_cfg(input int p, input int s, input int nper,
                           input int pause_j, input string tag);
        int seff;
        int j;
        int highs;
        int len;
        bit paused;
        bit fell;
        bit rose_mid;
        int idx;
        int expd;
        seff = (s > p) ? s : p;
        rst = 1'b1;
        en  = 1'b0;
        per = PW'(p);
        stp = DW'(s);
        repeat (3) @(negedge clk);
        check(!pwm && !st, "R1 reset state", int'(pwm) + int'(st), 0);
        rst = 1'b0;
        en  = 1'b1;
        j = 0; highs = 0; len = 0; paused = 1'b0; fell = 1'b0; rose_mid = 1'b0;
        while (j <= nper) begin
            @(negedge clk);
            if (st) begin
                if (j == 0) begin
                    check(highs == 0, "R1 first period low", highs, 0);
                    check(len == p - 1, "R2 first start", len, p - 1);
                end else begin
                    idx  = ((j * p - 1) / seff) % N;
                    expd = (p * code_of(idx)) >> CW;
                    check(highs == expd, tag, highs, expd);
                    if (!paused) begin
                        check(len == p, "R2 period length", len, p);
                        check(!rose_mid, "R8 single pulse", int'(rose_mid), 0);
                    end
                end
                j++;
                highs = 0; len = 0; paused = 1'b0; fell = 1'b0; rose_mid = 1'b0;
            end
            if (pwm && fell) rose_mid = 1'b1;
            if (!pwm && len > 0) fell = 1'b1;
            if (!pwm && len == 0) fell = 1'b1;
            highs += int'(pwm);
            len++;
            if (j == pause_j && len == 3) begin
                en = 1'b0;
                repeat (7) begin
                    @(negedge clk);
                    check(!pwm && !st, "R9 hold quiet", int'(pwm) + int'(st), 0);
                end
                en = 1'b1;
                paused = 1'b1;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // Step equals period: one entry per period, index wraps twice (R5, R7)
        run_cfg(20, 20, 40, -1, "R3 R5 R7 duty");
        // Step three periods long
        run_cfg(20, 60, 50, -1, "R5 slow step duty");
        // Step faster than carrier is clamped to the carrier length
        run_cfg(24, 5, 40, -1, "R6 clamped step duty");
        // Non-multiple step with a pause inside period 5
        run_cfg(40, 100, 30, 5, "R9 resume duty");
        // Long period resolves the table codes finely
        run_cfg(250, 500, 40, -1, "R4 code duty");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule